// File: doc/BRIEF.md
# Interrupt Arbitration and Vector Fetch Sequencer

This block sits beside the execution unit of a 16-bit processor core and decides, each time an instruction completes, whether control must divert into a service routine. It weighs synchronous exceptions and software-raised interrupts, a non-maskable request pin, a maskable request pin and single-step tracing, picks one, and determines the 8-bit interrupt type. For the maskable pin the type is obtained from an external controller through two acknowledge pulses.

Once a source is chosen the block runs the entry sequence on its own. It saves the current flags, code segment and return offset as three stack word writes. It raises a one-cycle request to clear the interrupt-enable and trap flags. It then reads the four bytes of the routine pointer from the vector table in low memory and hands the new segment and offset to the fetch unit with a done strobe. Memory traffic uses simple request/acknowledge ports, and each request stays up until it is acknowledged.

Top module: `intr_entry_seq`

## Requirements
- R1: After a synchronous reset the block is idle: `busy`, `inta_pulse`, `wr_req`, `rd_req`, `clr_if_tf` and `done` are low, and `new_cs`/`new_ip` read 0. At most one of `inta_pulse`, `wr_req`, `rd_req`, `clr_if_tf` and `done` is high in any cycle.
- R2: A source is considered only in a cycle where `boundary` is high and the block is idle. Strobes that arrive without `boundary`, or while an entry is under way, start nothing. The only exception is the non-maskable edge described in R4.
- R3: Fixed priority, highest first: divide error (type 0), overflow trap `into_req` with `of_flag`=1 (type 4), software interrupt (type `swint_type`, so 3 is a breakpoint), non-maskable request (type 2), maskable request (type from controller), single step with `tf_flag`=1 (type 1).
- R4: A rising edge on `nmi_pin` is remembered until it is serviced, even if the pin has fallen by then. A pin held high yields exactly one entry.
- R5: `intr_pin` is a level: it is taken only if it is high together with `if_flag`=1 at an accepted boundary, and it is not remembered otherwise.
- R6: A maskable entry starts with two one-cycle `inta_pulse` cycles separated by one quiet cycle. The type byte is taken from `inta_data` during the second pulse.
- R7: The entry writes three words in this order: flags, CS, IP. These are the values of `flags_in`, `cs_in` and `ip_in` at acceptance. Each write is held with stable data until `wr_ack`.
- R8: One cycle of `clr_if_tf` follows the last write and precedes the first table read.
- R9: The table is read one byte at a time at addresses type×4+0, +1, +2, +3 in that order, each held until `rd_ack`. Bytes 0 and 1 are the low and high bytes of the new IP. Bytes 2 and 3 are the low and high bytes of the new CS.
- R10: `done` is high for one cycle with the assembled `new_cs`/`new_ip`, and the block is idle in the next cycle.
- R11: `into_req` with `of_flag`=0 has no effect: the boundary is decided as if it were absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Instruction-boundary strobe |
| nmi_pin | input | 1 | Non-maskable request, edge sensitive |
| intr_pin | input | 1 | Maskable request, level sensitive |
| if_flag | input | 1 | Interrupt-enable flag |
| tf_flag | input | 1 | Trap (single-step) flag |
| of_flag | input | 1 | Overflow flag |
| div_err | input | 1 | Divide-error exception |
| into_req | input | 1 | Overflow-trap instruction executed |
| swint_req | input | 1 | Software interrupt instruction executed |
| swint_type | input | 8 | Type operand of the software interrupt |
| flags_in | input | 16 | Current flags word |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Return offset |
| inta_pulse | output | 1 | Interrupt acknowledge pulse |
| inta_data | input | 8 | Type byte from the interrupt controller |
| wr_req | output | 1 | Stack word write request |
| wr_data | output | 16 | Word to push |
| wr_ack | input | 1 | Write accepted |
| rd_req | output | 1 | Vector table byte read request |
| rd_addr | output | 10 | Vector table byte address |
| rd_data | input | 8 | Read byte, valid with `rd_ack` |
| rd_ack | input | 1 | Read completed |
| clr_if_tf | output | 1 | Clear interrupt-enable and trap flags |
| done | output | 1 | New CS:IP valid |
| new_cs | output | 16 | Routine segment |
| new_ip | output | 16 | Routine offset |
| busy | output | 1 | Entry sequence in progress |

## Verification
The bench targets simultaneous requests at one boundary, where a wrong priority order services the wrong type or takes a lower source first. It covers a non-maskable pulse that ends before any boundary: a design that only sees the pin level would lose it, and one that does not consume its latch would enter twice for a held pin. It drives the maskable pin while interrupts are disabled and checks that the overflow trap is refused when the overflow flag is clear, because a leaky gate there raises spurious entries. It stalls the write and read acknowledges and changes the saved state during an entry, so that skipped words, out-of-order bytes, swapped halves or values taken late all show up as wrong pushes or a wrong routine address.

// File: rtl/intr_seq_pkg.sv
`timescale 1ns/1ps
package intr_seq_pkg;

    localparam int TYPE_W      = 8;
    localparam int WORD_W      = 16;
    localparam int BYTE_W      = 8;
    localparam int ENTRY_BYTES = 4;
    localparam int PUSH_WORDS  = 3;
    localparam int IDX_W       = $clog2(ENTRY_BYTES);
    localparam int VTA_W       = TYPE_W + IDX_W;
    localparam int PTR_W       = ENTRY_BYTES * BYTE_W;

    localparam logic [TYPE_W-1:0] T_DIVIDE = 8'd0;
    localparam logic [TYPE_W-1:0] T_STEP   = 8'd1;
    localparam logic [TYPE_W-1:0] T_NMI    = 8'd2;
    localparam logic [TYPE_W-1:0] T_OVF    = 8'd4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ACK1, ST_GAP, ST_ACK2, ST_PUSH, ST_CLEAR, ST_READ, ST_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_DIV, SRC_OVF, SRC_SOFT, SRC_NMI, SRC_EXT, SRC_STEP
    } src_e;

    typedef struct packed {
        logic              valid;
        logic              ext;
        logic [TYPE_W-1:0] vtype;
    } grant_t;

    function automatic logic [VTA_W-1:0] entry_addr(input logic [TYPE_W-1:0] t,
                                                    input logic [IDX_W-1:0]  i);
        return {t, i};
    endfunction

endpackage

// File: rtl/intr_arbiter.sv
`timescale 1ns/1ps
module intr_arbiter
    import intr_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              eval,
    input  logic              nmi_pin,
    input  logic              intr_pin,
    input  logic              if_flag,
    input  logic              tf_flag,
    input  logic              of_flag,
    input  logic              div_err,
    input  logic              into_req,
    input  logic              swint_req,
    input  logic [TYPE_W-1:0] swint_type,
    output grant_t            grant
);

    logic nmi_prev;
    logic nmi_pend;
    logic nmi_seen;
    src_e src;

    assign nmi_seen = nmi_pend | (nmi_pin & ~nmi_prev);

    always_comb begin
        if (div_err)                 src = SRC_DIV;
        else if (into_req && of_flag) src = SRC_OVF;
        else if (swint_req)          src = SRC_SOFT;
        else if (nmi_seen)           src = SRC_NMI;
        else if (intr_pin && if_flag) src = SRC_EXT;
        else if (tf_flag)            src = SRC_STEP;
        else                         src = SRC_NONE;
    end

    always_comb begin
        grant.valid = eval && (src != SRC_NONE);
        grant.ext   = (src == SRC_EXT);
        case (src)
            SRC_DIV:  grant.vtype = T_DIVIDE;
            SRC_OVF:  grant.vtype = T_OVF;
            SRC_SOFT: grant.vtype = swint_type;
            SRC_NMI:  grant.vtype = T_NMI;
            SRC_STEP: grant.vtype = T_STEP;
            default:  grant.vtype = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_prev <= nmi_pin;
            nmi_pend <= nmi_seen & ~(grant.valid && src == SRC_NMI);
        end
    end

    // R4
    nmi_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (nmi_pend && !eval) |=> nmi_pend);

endmodule

// File: rtl/intr_entry_fsm.sv
`timescale 1ns/1ps
module intr_entry_fsm
    import intr_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  grant_t            grant,
    input  logic [WORD_W-1:0] flags_in,
    input  logic [WORD_W-1:0] cs_in,
    input  logic [WORD_W-1:0] ip_in,
    input  logic [TYPE_W-1:0] inta_data,
    input  logic              wr_ack,
    input  logic              rd_ack,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              idle,
    output logic              inta_pulse,
    output logic              wr_req,
    output logic [WORD_W-1:0] wr_data,
    output logic              rd_req,
    output logic [VTA_W-1:0]  rd_addr,
    output logic              clr_if_tf,
    output logic              done,
    output logic [WORD_W-1:0] new_cs,
    output logic [WORD_W-1:0] new_ip
);

    seq_state_e        state;
    logic [IDX_W-1:0]  pos;
    logic [TYPE_W-1:0] type_q;
    logic [WORD_W-1:0] flags_q, cs_q, ip_q;
    logic [PTR_W-1:0]  ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pos     <= '0;
            type_q  <= '0;
            flags_q <= '0;
            cs_q    <= '0;
            ip_q    <= '0;
            ptr_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (grant.valid) begin
                    type_q  <= grant.vtype;
                    flags_q <= flags_in;
                    cs_q    <= cs_in;
                    ip_q    <= ip_in;
                    pos     <= '0;
                    state   <= grant.ext ? ST_ACK1 : ST_PUSH;
                end
                ST_ACK1: state <= ST_GAP;
                ST_GAP:  state <= ST_ACK2;
                ST_ACK2: begin
                    type_q <= inta_data;
                    state  <= ST_PUSH;
                end
                ST_PUSH: if (wr_ack) begin
                    if (pos == IDX_W'(PUSH_WORDS - 1)) begin
                        pos   <= '0;
                        state <= ST_CLEAR;
                    end else begin
                        pos <= pos + 1'b1;
                    end
                end
                ST_CLEAR: state <= ST_READ;
                ST_READ: if (rd_ack) begin
                    ptr_q[int'(pos)*BYTE_W +: BYTE_W] <= rd_data;
                    if (pos == IDX_W'(ENTRY_BYTES - 1)) state <= ST_DONE;
                    else                                pos   <= pos + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (pos)
            IDX_W'(0): wr_data = flags_q;
            IDX_W'(1): wr_data = cs_q;
            default:   wr_data = ip_q;
        endcase
    end

    assign idle       = (state == ST_IDLE);
    assign inta_pulse = (state == ST_ACK1) || (state == ST_ACK2);
    assign wr_req     = (state == ST_PUSH);
    assign rd_req     = (state == ST_READ);
    assign rd_addr    = entry_addr(type_q, pos);
    assign clr_if_tf  = (state == ST_CLEAR);
    assign done       = (state == ST_DONE);
    assign new_ip     = ptr_q[WORD_W-1:0];
    assign new_cs     = ptr_q[PTR_W-1:WORD_W];

    // R1
    one_action_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({inta_pulse, wr_req, rd_req, clr_if_tf, done}));
    // R6
    inta_single_chk: assert property (@(posedge clk) disable iff (rst)
        inta_pulse |=> !inta_pulse);
    // R7
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_data)));
    // R8
    clr_then_read_chk: assert property (@(posedge clk) disable iff (rst)
        clr_if_tf |=> (rd_req && rd_addr[IDX_W-1:0] == '0));
    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
    // R10
    done_release_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (idle && !done));

endmodule

// File: rtl/intr_entry_seq.sv
`timescale 1ns/1ps
module intr_entry_seq
    import intr_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary,
    input  logic              nmi_pin,
    input  logic              intr_pin,
    input  logic              if_flag,
    input  logic              tf_flag,
    input  logic              of_flag,
    input  logic              div_err,
    input  logic              into_req,
    input  logic              swint_req,
    input  logic [TYPE_W-1:0] swint_type,
    input  logic [WORD_W-1:0] flags_in,
    input  logic [WORD_W-1:0] cs_in,
    input  logic [WORD_W-1:0] ip_in,
    output logic              inta_pulse,
    input  logic [TYPE_W-1:0] inta_data,
    output logic              wr_req,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_ack,
    output logic              rd_req,
    output logic [VTA_W-1:0]  rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              rd_ack,
    output logic              clr_if_tf,
    output logic              done,
    output logic [WORD_W-1:0] new_cs,
    output logic [WORD_W-1:0] new_ip,
    output logic              busy
);

    logic   idle;
    grant_t grant;

    intr_arbiter u_arb (
        .clk(clk), .rst(rst), .eval(boundary & idle),
        .nmi_pin(nmi_pin), .intr_pin(intr_pin), .if_flag(if_flag),
        .tf_flag(tf_flag), .of_flag(of_flag), .div_err(div_err),
        .into_req(into_req), .swint_req(swint_req), .swint_type(swint_type),
        .grant(grant)
    );

    intr_entry_fsm u_fsm (
        .clk(clk), .rst(rst), .grant(grant),
        .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in),
        .inta_data(inta_data), .wr_ack(wr_ack), .rd_ack(rd_ack), .rd_data(rd_data),
        .idle(idle), .inta_pulse(inta_pulse), .wr_req(wr_req), .wr_data(wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .clr_if_tf(clr_if_tf), .done(done),
        .new_cs(new_cs), .new_ip(new_ip)
    );

    assign busy = ~idle;

    // R2
    no_start_without_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && !boundary) |=> idle);

endmodule

// File: tb/test_intr_entry_seq.sv
`timescale 1ns/1ps
module test_intr_entry_seq;
    import intr_seq_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, boundary, nmi_pin, intr_pin, if_flag, tf_flag, of_flag;
    logic div_err, into_req, swint_req;
    logic [7:0]  swint_type, inta_data, rd_data;
    logic [15:0] flags_in, cs_in, ip_in, wr_data, new_cs, new_ip;
    logic inta_pulse, wr_req, wr_ack, rd_req, rd_ack, clr_if_tf, done, busy;
    logic [9:0] rd_addr;

    intr_entry_seq i_intr_entry_seq (
        .clk(clk), .rst(rst), .boundary(boundary), .nmi_pin(nmi_pin),
        .intr_pin(intr_pin), .if_flag(if_flag), .tf_flag(tf_flag), .of_flag(of_flag),
        .div_err(div_err), .into_req(into_req), .swint_req(swint_req),
        .swint_type(swint_type), .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in),
        .inta_pulse(inta_pulse), .inta_data(inta_data), .wr_req(wr_req),
        .wr_data(wr_data), .wr_ack(wr_ack), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_ack(rd_ack), .clr_if_tf(clr_if_tf), .done(done),
        .new_cs(new_cs), .new_ip(new_ip), .busy(busy)
    );

    // Memory and acknowledge pattern
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;
    assign wr_ack = (cyc % 3) != 0;
    assign rd_ack = (cyc % 4) != 1;

    function automatic logic [7:0] mem_byte(input logic [9:0] a);
        return 8'((int'(a) * 37 + 11) & 255);
    endfunction
    assign rd_data = mem_byte(rd_addr);

    // Reference model
    typedef struct {
        bit inta, wr, rd, clr, dn;
        bit [15:0] wdata, ncs, nip;
        bit [9:0] raddr;
        int hs;
    } exp_t;

    exp_t q[$];
    bit m_prev = 0, m_pend = 0;
    string tag = "R1";
    int compared = 0, mismatched = 0;

    task automatic chk(input bit ok, input string what, input longint act, input longint expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, expv, cyc);
        end
    endtask

    task automatic push_entry(input bit [7:0] t, input bit ext);
        exp_t e;
        bit [9:0] base;
        bit [15:0] wv;
        base = {t, 2'b00};
        e = '{default: 0};
        if (ext) begin
            e.inta = 1; q.push_back(e);
            e.inta = 0; q.push_back(e);
            e.inta = 1; q.push_back(e);
            e.inta = 0;
        end
        for (int i = 0; i < 3; i++) begin
            wv = (i == 0) ? flags_in : (i == 1) ? cs_in : ip_in;
            e = '{default: 0}; e.wr = 1; e.wdata = wv; e.hs = 1; q.push_back(e);
        end
        e = '{default: 0}; e.clr = 1; q.push_back(e);
        for (int i = 0; i < 4; i++) begin
            e = '{default: 0}; e.rd = 1; e.raddr = base + 10'(i); e.hs = 2; q.push_back(e);
        end
        e = '{default: 0}; e.dn = 1;
        e.nip = {mem_byte(base + 10'd1), mem_byte(base)};
        e.ncs = {mem_byte(base + 10'd3), mem_byte(base + 10'd2)};
        q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            exp_t e;
            bit busy_now;
            busy_now = (q.size() != 0);
            e = '{default: 0};
            if (busy_now) e = q[0];
            chk(busy === busy_now, "busy", busy, busy_now);
            chk(inta_pulse === e.inta, "inta_pulse", inta_pulse, e.inta);
            chk(wr_req === e.wr, "wr_req", wr_req, e.wr);
            if (e.wr) chk(wr_data === e.wdata, "wr_data", wr_data, e.wdata);
            chk(rd_req === e.rd, "rd_req", rd_req, e.rd);
            if (e.rd) chk(rd_addr === e.raddr, "rd_addr", rd_addr, e.raddr);
            chk(clr_if_tf === e.clr, "clr_if_tf", clr_if_tf, e.clr);
            chk(done === e.dn, "done", done, e.dn);
            if (e.dn) begin
                chk(new_cs === e.ncs, "new_cs", new_cs, e.ncs);
                chk(new_ip === e.nip, "new_ip", new_ip, e.nip);
            end
            if (busy_now && (e.hs == 0 || (e.hs == 1 && wr_ack) || (e.hs == 2 && rd_ack)))
                void'(q.pop_front());
            if (nmi_pin && !m_prev) m_pend = 1;
            m_prev = nmi_pin;
            if (!busy_now && boundary) begin
                if (div_err)                  push_entry(8'd0, 0);
                else if (into_req && of_flag) push_entry(8'd4, 0);
                else if (swint_req)           push_entry(swint_type, 0);
                else if (m_pend) begin        push_entry(8'd2, 0); m_pend = 0; end
                else if (intr_pin && if_flag) push_entry(inta_data, 1);
                else if (tf_flag)             push_entry(8'd1, 0);
            end
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic pulse_boundary();
        boundary = 1; tick(); boundary = 0;
    endtask

    task automatic settle();
        tick(2);
        while (q.size() != 0) tick();
        tick(2);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired (tag %s)", tag);
        finish_run();
    end

    initial begin
        rst = 1; boundary = 0; nmi_pin = 0; intr_pin = 0; if_flag = 0; tf_flag = 0;
        of_flag = 0; div_err = 0; into_req = 0; swint_req = 0; swint_type = 8'h00;
        flags_in = 16'hF202; cs_in = 16'h1234; ip_in = 16'h5678; inta_data = 8'h5A;
        tick(4);
        rst = 0;
        // R1: reset state, compared each idle cycle
        tag = "R1"; tick(2);
        chk(new_cs === 16'h0 && new_ip === 16'h0, "new_cs_ip_reset", {new_cs, new_ip}, 0);

        // R3: single step type 1
        tag = "R3_step"; tf_flag = 1; pulse_boundary(); tf_flag = 0; settle();

        // R5: maskable ignored with IF=0, then taken with IF=1 (R6 acknowledge pair)
        tag = "R5_masked"; intr_pin = 1; pulse_boundary(); tick(3);
        tag = "R6_inta"; if_flag = 1; pulse_boundary(); intr_pin = 0; settle();
        tag = "R5_level"; intr_pin = 1; tick(2); intr_pin = 0; tick(2); pulse_boundary(); settle();

        // R4: short NMI pulse between boundaries, then held pin gives one entry
        tag = "R4_latch"; nmi_pin = 1; tick(); nmi_pin = 0; tick(5); pulse_boundary(); settle();
        tag = "R4_held"; nmi_pin = 1; tick(2); pulse_boundary(); settle();
        pulse_boundary(); settle(); nmi_pin = 0; tick(2);

        // R3: everything at once, drained one boundary at a time
        tag = "R3_prio"; if_flag = 1; intr_pin = 1; tf_flag = 1; inta_data = 8'hC3;
        nmi_pin = 1; tick(); div_err = 1; pulse_boundary(); div_err = 0; nmi_pin = 0; settle();
        pulse_boundary(); settle();   // NMI
        pulse_boundary(); settle();   // maskable
        intr_pin = 0; pulse_boundary(); settle(); // single step
        tf_flag = 0;

        // R11: overflow trap refused when OF=0, breakpoint taken instead
        tag = "R11_noovf"; into_req = 1; swint_req = 1; swint_type = 8'h03;
        pulse_boundary(); settle();
        tag = "R11_alone"; swint_req = 0; pulse_boundary(); settle();
        tag = "R3_ovf"; of_flag = 1; swint_req = 1; pulse_boundary(); settle();
        into_req = 0; of_flag = 0; swint_req = 0;

        // R2: strobes without boundary, and boundary held through entries
        tag = "R2_noboundary"; swint_req = 1; swint_type = 8'h21; div_err = 1; tick(6);
        div_err = 0;
        tag = "R2_busy"; boundary = 1; tick(40); boundary = 0; swint_req = 0; settle();

        // R7: saved state changes during entry; values at acceptance must be pushed
        tag = "R7_capture"; flags_in = 16'h0A55; cs_in = 16'hBEEF; ip_in = 16'h0102;
        swint_req = 1; swint_type = 8'hFF; pulse_boundary(); swint_req = 0;
        flags_in = 16'h1111; cs_in = 16'h2222; ip_in = 16'h3333; settle();

        // R9/R10: type with high table address, maskable path
        tag = "R9_R10_ext"; inta_data = 8'h80; intr_pin = 1; if_flag = 1;
        pulse_boundary(); intr_pin = 0; settle();
        tag = "R8_flagclr"; swint_req = 1; swint_type = 8'h10; pulse_boundary();
        swint_req = 0; settle();

        finish_run();
    end

endmodule